// File: doc/BRIEF.md
# Four-Step Trace Event Sequencer Bank

The block holds a bank of small sequencers that turn single-cycle match events into trace-control actions. Each sequencer has four ordered slots. A slot either waits for one chosen event bit or is marked as "don't care". A sequencer moves through its slots in order. When the last slot that waits for an event is satisfied, the sequencer raises its programmed action and returns to its first slot. It can then recognise the same pattern again.

Each sequencer is given one of four action codes: begin collection, record an address sample, record an address-plus-data sample, or end collection. Sequencers that share an action code are ORed onto that action's strobe. The strobes leave the block through one register stage.

A begin action clears the partial progress of every sequencer that does not begin collection. This keeps the counting for each packet separate. An end action that completes in the same cycle as a begin action overrides it.

Top module: `trseq_bank`

## Requirements
- R1: While `rst_ni` is low, all four strobes are 0 and every sequencer is held at slot 0, whatever the events and configuration.
- R2: A sequencer with an event in slot 0 and don't-care in slots 1 to 3 fires on every cycle in which that event is present.
- R3: A sequencer waiting for event A and then event B fires only when B is seen in a cycle later than the one where A was accepted. B before A, or A and B together from slot 0, does not fire it.
- R4: A sequencer programmed A, B, A, B fires only on the second B, after two complete A-then-B pairs.
- R5: After a sequencer fires, it restarts at slot 0 on the next cycle. An A-then-B sample sequence therefore fires once for each of two back-to-back A-then-B pairs.
- R6: A sequencer advances by at most one slot per cycle. A don't-care slot between two event slots is satisfied in the cycle it is current and uses up that one cycle.
- R7: Action codes map to strobes as follows: 0 to `start_o`, 1 to `asamp_o`, 2 to `dsamp_o`, 3 to `stop_o`. A strobe is high in the cycle after the one in which its sequence completed.
- R8: When a begin action takes effect, every sequencer whose action code is not 0 is returned to slot 0 on the next cycle, and its partial progress is discarded.
- R9: When a begin action and an end action complete in the same cycle, only `stop_o` is raised, and no sequencer is cleared by the suppressed begin.
- R10: Several sequencers that share an action code are ORed onto one strobe. That strobe is high for one cycle even when more than one of them completes.
- R11: A sequencer whose four slots are all don't-care never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 2**EVT_W (8) | Event bits from the match logic, one cycle each |
| cfg_use_i | input | 4*NUM_SEQ (16) | Bit 4*s+k set: slot k of sequencer s waits for an event; clear: don't-care |
| cfg_sel_i | input | 4*NUM_SEQ*EVT_W (48) | Event index for slot k of sequencer s at bits (4*s+k)*EVT_W upward |
| cfg_act_i | input | 2*NUM_SEQ (8) | Action code of sequencer s at bits 2*s+1:2*s |
| start_o | output | 1 | Begin-collection strobe |
| asamp_o | output | 1 | Address-sample strobe |
| dsamp_o | output | 1 | Address/data-sample strobe |
| stop_o | output | 1 | End-collection strobe |

## Verification
The bench drives a realistic packet pattern: a begin event, then two request/data pairs. It checks that the data-sample strobe fires on each pair and that the end strobe waits for the second pair. A design that did not re-arm would miss the second sample, and one that counted wrongly would stop early. It also presents B before A and A together with B from slot 0. A design that looked at a slot's successor in the same cycle would fire falsely on these.

The bench puts a begin between two partial stop sequences. If the clear were missing, the end strobe would appear two cycles too early. Further cases fire begin and end together, where a wrong priority would raise both strobes. Others use a middle don't-care slot, which a design that skipped it would complete a cycle early, and an all-don't-care sequencer, which must stay silent.

// File: rtl/trseq_pkg.sv
package trseq_pkg;

  localparam int unsigned SLOTS   = 4;
  localparam int unsigned SLOT_W  = 2;
  localparam int unsigned ACTIONS = 4;

  typedef enum logic [1:0] {
    ACT_START = 2'd0,
    ACT_ASAMP = 2'd1,
    ACT_DSAMP = 2'd2,
    ACT_STOP  = 2'd3
  } act_e;

  // Highest slot that waits for an event; 0 when none does.
  function automatic logic [SLOT_W-1:0] last_used_slot(input logic [SLOTS-1:0] use_bits);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (use_bits[k]) r = SLOT_W'(k);
    end
    return r;
  endfunction

  // Next slot index after a satisfied, non-final slot.
  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] cur);
    return SLOT_W'(cur + 1'b1);
  endfunction

endpackage

// File: rtl/trseq_step.sv
module trseq_step
  import trseq_pkg::*;
#(
  parameter int unsigned EVT_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [(1<<EVT_W)-1:0]    evt_i,
  input  logic [SLOTS-1:0]         use_i,
  input  logic [SLOTS*EVT_W-1:0]   sel_i,
  input  logic                     clr_i,
  output logic                     fire_o,
  output logic [SLOT_W-1:0]        pos_o
);

  logic [SLOT_W-1:0] pos_q, pos_d;
  logic [EVT_W-1:0]  cur_sel;
  logic              armed;
  logic              slot_hit;
  logic              at_last;
  logic [SLOT_W-1:0] last_slot;

  assign armed     = |use_i;
  assign last_slot = last_used_slot(use_i);
  assign cur_sel   = sel_i[pos_q*EVT_W +: EVT_W];
  assign slot_hit  = !use_i[pos_q] || evt_i[cur_sel];
  assign at_last   = (pos_q >= last_slot);
  assign fire_o    = armed && slot_hit && at_last;

  always_comb begin
    pos_d = pos_q;
    if (clr_i || fire_o || !armed) pos_d = '0;
    else if (slot_hit)             pos_d = next_slot(pos_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/trseq_action_merge.sv
module trseq_action_merge
  import trseq_pkg::*;
#(
  parameter int unsigned NUM_SEQ = 4
) (
  input  logic [NUM_SEQ-1:0]   fire_i,
  input  logic [2*NUM_SEQ-1:0] act_i,
  output logic [ACTIONS-1:0]   act_fire_o,
  output logic                 start_eff_o,
  output logic [NUM_SEQ-1:0]   clr_o
);

  always_comb begin
    act_fire_o = '0;
    for (int s = 0; s < NUM_SEQ; s++) begin
      if (fire_i[s]) act_fire_o[act_i[2*s +: 2]] = 1'b1;
    end
  end

  // End outranks begin when both complete together.
  assign start_eff_o = act_fire_o[ACT_START] && !act_fire_o[ACT_STOP];

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_clr
    assign clr_o[s] = start_eff_o && (act_i[2*s +: 2] != ACT_START);
  end

endmodule

// File: rtl/trseq_bank.sv
module trseq_bank
  import trseq_pkg::*;
#(
  parameter int unsigned NUM_SEQ = 4,
  parameter int unsigned EVT_W   = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [(1<<EVT_W)-1:0]            evt_i,
  input  logic [SLOTS*NUM_SEQ-1:0]         cfg_use_i,
  input  logic [SLOTS*NUM_SEQ*EVT_W-1:0]   cfg_sel_i,
  input  logic [2*NUM_SEQ-1:0]             cfg_act_i,
  output logic                             start_o,
  output logic                             asamp_o,
  output logic                             dsamp_o,
  output logic                             stop_o
);

  localparam int unsigned SEL_PER_SEQ = SLOTS * EVT_W;

  logic [NUM_SEQ-1:0]        seq_fire;
  logic [NUM_SEQ-1:0]        seq_clr;
  logic [SLOT_W*NUM_SEQ-1:0] seq_pos;
  logic [ACTIONS-1:0]        act_fire;
  logic                      start_eff;

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    trseq_step #(.EVT_W(EVT_W)) u_step (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i),
      .use_i  (cfg_use_i[s*SLOTS +: SLOTS]),
      .sel_i  (cfg_sel_i[s*SEL_PER_SEQ +: SEL_PER_SEQ]),
      .clr_i  (seq_clr[s]),
      .fire_o (seq_fire[s]),
      .pos_o  (seq_pos[s*SLOT_W +: SLOT_W])
    );
  end

  trseq_action_merge #(.NUM_SEQ(NUM_SEQ)) u_merge (
    .fire_i      (seq_fire),
    .act_i       (cfg_act_i),
    .act_fire_o  (act_fire),
    .start_eff_o (start_eff),
    .clr_o       (seq_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      asamp_o <= 1'b0;
      dsamp_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= start_eff;
      asamp_o <= act_fire[ACT_ASAMP];
      dsamp_o <= act_fire[ACT_DSAMP];
      stop_o  <= act_fire[ACT_STOP];
    end
  end

endmodule

// File: rtl/trseq_checker.sv
module trseq_checker #(
  parameter int unsigned NUM_SEQ = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_SEQ-1:0]    seq_fire,
  input logic [NUM_SEQ-1:0]    seq_clr,
  input logic [2*NUM_SEQ-1:0]  seq_pos,
  input logic [3:0]            act_fire,
  input logic                  start_o,
  input logic                  asamp_o,
  input logic                  dsamp_o,
  input logic                  stop_o
);

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!start_o && !stop_o) || !rst_ni);

  a_r7_start_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_fire[0] && !act_fire[3]) |=> start_o);

  a_r7_asamp_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_fire[1] |=> asamp_o);

  a_r7_dsamp_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_fire[2] |=> dsamp_o);

  a_r9_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_fire[3] |=> (stop_o && !start_o));

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq_chk
    a_r5_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_fire[s] |=> (seq_pos[2*s +: 2] == 2'd0));

    a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_clr[s] |=> (seq_pos[2*s +: 2] == 2'd0));

    a_r6_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((seq_pos[2*s +: 2] == $past(seq_pos[2*s +: 2])) ||
                (seq_pos[2*s +: 2] == 2'($past(seq_pos[2*s +: 2]) + 2'd1)) ||
                (seq_pos[2*s +: 2] == 2'd0)));
  end

endmodule

bind trseq_bank trseq_checker #(.NUM_SEQ(NUM_SEQ)) u_trseq_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .seq_fire (seq_fire),
  .seq_clr  (seq_clr),
  .seq_pos  (seq_pos),
  .act_fire (act_fire),
  .start_o  (start_o),
  .asamp_o  (asamp_o),
  .dsamp_o  (dsamp_o),
  .stop_o   (stop_o)
);

// File: tb/test_trseq_bank.sv
module test_trseq_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEQ    = 4;
  localparam int EVT_W      = 3;

  // expected vector bit order: {stop, dsamp, asamp, start}
  localparam logic [3:0] X_NONE  = 4'b0000;
  localparam logic [3:0] X_START = 4'b0001;
  localparam logic [3:0] X_ASAMP = 4'b0010;
  localparam logic [3:0] X_DSAMP = 4'b0100;
  localparam logic [3:0] X_STOP  = 4'b1000;

  logic                           clk = 1'b0;
  logic                           rst_n = 1'b0;
  logic [(1<<EVT_W)-1:0]          evt = '0;
  logic [4*NUM_SEQ-1:0]           cfg_use = '0;
  logic [4*NUM_SEQ*EVT_W-1:0]     cfg_sel = '0;
  logic [2*NUM_SEQ-1:0]           cfg_act = '0;
  logic start_o, asamp_o, dsamp_o, stop_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  trseq_bank #(.NUM_SEQ(NUM_SEQ), .EVT_W(EVT_W)) i_trseq_bank (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .evt_i     (evt),
    .cfg_use_i (cfg_use),
    .cfg_sel_i (cfg_sel),
    .cfg_act_i (cfg_act),
    .start_o   (start_o),
    .asamp_o   (asamp_o),
    .dsamp_o   (dsamp_o),
    .stop_o    (stop_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      logic [3:0] act;
      act = {stop_o, dsamp_o, asamp_o, start_o};
      checks++;
      if (act !== sb[0].exp) begin
        errors++;
        $display("FAIL %s: cycle %0d strobes actual %b expected %b",
                 sb[0].tag, cyc, act, sb[0].exp);
      end
      void'(sb.pop_front());
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: apply events, expect strobes one cycle later
  task automatic step(input logic [7:0] ev, input logic [3:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    evt = ev[(1<<EVT_W)-1:0];
    it.due = cyc + 1;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic set_seq(input int s, input logic [3:0] use_bits,
                         input int e0, input int e1, input int e2, input int e3,
                         input logic [1:0] act);
    cfg_use[4*s +: 4] = use_bits;
    cfg_sel[(4*s+0)*EVT_W +: EVT_W] = EVT_W'(e0);
    cfg_sel[(4*s+1)*EVT_W +: EVT_W] = EVT_W'(e1);
    cfg_sel[(4*s+2)*EVT_W +: EVT_W] = EVT_W'(e2);
    cfg_sel[(4*s+3)*EVT_W +: EVT_W] = EVT_W'(e3);
    cfg_act[2*s +: 2] = act;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    evt = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // packet profile: begin on e0, addr on e1, data on e1 then e2, end on two pairs
  task automatic cfg_packet();
    set_seq(0, 4'b0001, 0, 0, 0, 0, 2'd0);
    set_seq(1, 4'b0001, 1, 0, 0, 0, 2'd1);
    set_seq(2, 4'b0011, 1, 2, 0, 0, 2'd2);
    set_seq(3, 4'b1111, 1, 2, 1, 2, 2'd3);
  endtask

  localparam logic [7:0] E0 = 8'h01, E1 = 8'h02, E2 = 8'h04, E3 = 8'h08;
  localparam logic [7:0] E4 = 8'h10, E5 = 8'h20, E6 = 8'h40, E7 = 8'h80;

  initial begin
    cfg_packet();
    // R1: events applied while reset is held produce nothing
    step(E0, X_NONE, "R1");
    step(E1, X_NONE, "R1");
    step(E0 | E1, X_NONE, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    evt = '0;

    // R2 R4 R5 R7: begin, then two request/data pairs
    step(E0, X_START, "R7 start");
    step(E1, X_ASAMP, "R2 addr sample");
    step(E2, X_DSAMP, "R5 first data sample");
    step(E1, X_ASAMP, "R2 addr sample again");
    step(E2, X_DSAMP | X_STOP, "R4 stop after second pair");
    step(8'h00, X_NONE, "R5 idle");

    // R3: ordering of A then B
    do_reset();
    step(E2, X_NONE, "R3 B before A");
    step(E1 | E2, X_ASAMP, "R3 A and B together");
    step(8'h00, X_NONE, "R3 idle");
    step(E2, X_DSAMP, "R3 B after A");
    // R8: begin wipes the end sequencer's progress (it sits at slot 2)
    step(E0, X_START, "R8 begin");
    step(E1, X_ASAMP, "R8 restart pair one");
    step(E2, X_DSAMP, "R8 no early stop");
    step(E1, X_ASAMP, "R8 pair two request");
    step(E2, X_DSAMP | X_STOP, "R8 stop after fresh count");

    // R9 R6 R11
    do_reset();
    @(negedge clk);
    set_seq(0, 4'b0001, 3, 0, 0, 0, 2'd0);
    set_seq(1, 4'b0001, 3, 0, 0, 0, 2'd3);
    set_seq(2, 4'b0000, 0, 0, 0, 0, 2'd2);
    set_seq(3, 4'b0101, 4, 0, 5, 0, 2'd1);
    step(E3, X_STOP, "R9 stop beats start");
    step(E4, X_NONE, "R11 all ignore silent");
    step(E5, X_NONE, "R6 middle ignore uses a cycle");
    step(E5, X_ASAMP, "R6 fires after ignore slot");
    step(E4 | E5, X_NONE, "R6 one slot per cycle");
    step(8'h00, X_NONE, "R6 ignore slot");
    step(8'h00, X_NONE, "R11 idle");
    step(E5, X_ASAMP, "R6 completes");

    // R10: shared action code
    do_reset();
    @(negedge clk);
    set_seq(0, 4'b0001, 6, 0, 0, 0, 2'd1);
    set_seq(1, 4'b0001, 7, 0, 0, 0, 2'd1);
    set_seq(2, 4'b0000, 0, 0, 0, 0, 2'd0);
    set_seq(3, 4'b0000, 0, 0, 0, 0, 2'd3);
    step(E6, X_ASAMP, "R10 first source");
    step(E7, X_ASAMP, "R10 second source");
    step(E6 | E7, X_ASAMP, "R10 both sources");
    step(8'h00, X_NONE, "R10 idle");

    step(8'h00, X_NONE, "R11 final idle");
    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      report();
    end
  end

endmodule